// File: doc/BRIEF.md
# Bandwidth-Limited In-Order Retire Controller

This block decides, every cycle, how many instructions leave the head of a reorder buffer. It looks at a window of up to `WIDTH` of the oldest entries. Each entry has a ready flag and a descriptor: executed, squashed, needs in-order execution (non-speculative or barrier), uncached load, store, fault, and a sequence number. The block walks the window from the oldest slot. It produces one retire strobe per slot, so the strobes always form a contiguous run starting at the oldest slot.

Squashed entries are dropped without counting as commits. Executed entries without a fault commit. An entry that must execute in order, or that carries a fault, is acted on only when two things hold: no instruction has committed ahead of it in the same cycle, and no store is waiting for writeback. Such an entry either sends an execute request back to the issue logic or raises a trap. A trap puts the controller into a wait period of `TRAP_LAT` cycles. At the end of that period a one-cycle squash trigger fires.

The block also produces two other outputs. One is an empty indication for earlier pipeline stages. The other is a counter of cycles in which the full retire bandwidth was used.

Top module: `retire_ctrl`

## Requirements
- R1: Retire strobes form a contiguous run from slot 0 (slot 0 is the oldest). The walk stops at the first slot that is not ready, not retirable, or that raises a request.
- R2: A ready squashed entry is retired (its strobe is set) but is not counted in `commit_count`. It does not make later entries "not first".
- R3: While `intr_pending` is high, no entry is retired and no request or trap is raised.
- R4: An unexecuted entry flagged in-order (`hd_nonspec`) or uncached load (`hd_uncached`) raises `ns_req`, with `ns_seq` set to its sequence number. This happens only when no commit precedes it in the cycle and `stores_pending` is low. Otherwise nothing is raised. In both cases the walk stops at that entry.
- R5: When the entry raising `ns_req` is an uncached load, `ns_uncached` is also high.
- R6: An executed faulting entry raises `trap_req` only as the first commit candidate of the cycle with `stores_pending` low. It is never retired. Otherwise it only stops the walk.
- R7: After a cycle with `trap_req`, `trap_wait` is high for `TRAP_LAT` cycles. During that time nothing is retired and no new fault or request is acted on.
- R8: `trap_squash` is high for exactly one cycle. That cycle is `TRAP_LAT` cycles after the `trap_req` cycle, and it is the last cycle of the wait.
- R9: `rob_empty_out` is high only when `rob_empty` is high, `stores_pending` is low, and no store commits in the same cycle.
- R10: `full_bw_count` increments by one after every cycle in which `commit_count` equals `WIDTH`. Otherwise it holds its value.
- R11: When at least one entry commits, `done_valid` is high and `done_seq` is the sequence number of the youngest entry committed that cycle.
- R12: After reset, `full_bw_count` is 0, and `trap_wait` and `trap_squash` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| head_rdy | input | WIDTH | Per-slot entry ready, bit 0 oldest |
| hd_exec | input | WIDTH | Entry has executed |
| hd_squashed | input | WIDTH | Entry was squashed |
| hd_nonspec | input | WIDTH | Entry must execute in order (non-speculative or barrier) |
| hd_uncached | input | WIDTH | Entry is an uncached load |
| hd_store | input | WIDTH | Entry is a store |
| hd_fault | input | WIDTH | Entry carries a fault |
| hd_seq | input | WIDTH*SEQ_W | Sequence numbers, slot i at bits i*SEQ_W |
| stores_pending | input | 1 | Stores await writeback |
| intr_pending | input | 1 | Interrupt pending |
| rob_empty | input | 1 | Buffer holds no entries |
| retire_mask | output | WIDTH | Retire strobe per slot |
| commit_count | output | $clog2(WIDTH+1) | Entries committed this cycle |
| done_valid | output | 1 | A commit happened this cycle |
| done_seq | output | SEQ_W | Youngest committed sequence number |
| ns_req | output | 1 | In-order execute request |
| ns_uncached | output | 1 | Request is for an uncached load |
| ns_seq | output | SEQ_W | Sequence number of requested entry |
| trap_req | output | 1 | Fault accepted this cycle |
| trap_wait | output | 1 | Trap latency wait active |
| trap_squash | output | 1 | Trap squash trigger |
| rob_empty_out | output | 1 | Empty broadcast |
| full_bw_count | output | CNT_W | Cycles at full bandwidth |

## Verification
The assertions assume a valid head window. Readiness is never reported for a slot beyond an absent entry in a way that matters. At most one of the in-order, uncached and fault flags is relevant per entry. The stimulus keeps every descriptor self-consistent: faults appear only on executed entries, and in-order flags appear only on unexecuted ones. The stimulus also removes the faulting window before the wait ends, so that a second trap is raised only on purpose.

// File: rtl/retire_ctrl_pkg.sv
package retire_ctrl_pkg;
   typedef enum logic {
      MODE_RUN  = 1'b0,
      MODE_WAIT = 1'b1
   } rc_mode_e;

   function automatic int unsigned rc_cw(input int unsigned w);
      return $clog2(w + 1);
   endfunction
endpackage

// File: rtl/retire_scan.sv
module retire_scan #(
   parameter int WIDTH = 4,
   parameter int SEQ_W = 16,
   localparam int CW = $clog2(WIDTH + 1)
) (
   input  logic                   enable,
   input  logic                   stores_pending,
   input  logic [WIDTH-1:0]       head_rdy,
   input  logic [WIDTH-1:0]       hd_exec,
   input  logic [WIDTH-1:0]       hd_squashed,
   input  logic [WIDTH-1:0]       hd_nonspec,
   input  logic [WIDTH-1:0]       hd_uncached,
   input  logic [WIDTH-1:0]       hd_store,
   input  logic [WIDTH-1:0]       hd_fault,
   input  logic [WIDTH*SEQ_W-1:0] hd_seq,
   output logic [WIDTH-1:0]       retire_mask,
   output logic [CW-1:0]          commit_count,
   output logic                   done_valid,
   output logic [SEQ_W-1:0]       done_seq,
   output logic                   ns_req,
   output logic                   ns_uncached,
   output logic [SEQ_W-1:0]       ns_seq,
   output logic                   fault_hit,
   output logic                   store_commit
);
   logic [WIDTH:0]    alive;
   logic [CW-1:0]     ncom [WIDTH+1];
   logic [WIDTH-1:0]  commit_v, ns_v, flt_v;

   assign alive[0] = enable;
   assign ncom[0]  = '0;

   for (genvar i = 0; i < WIDTH; i++) begin : g_slot
      logic rdy, sq, first, ok, ns_cand;
      assign rdy     = alive[i] & head_rdy[i];
      assign sq      = rdy & hd_squashed[i];
      assign first   = (ncom[i] == '0) & ~stores_pending;
      assign ok      = rdy & ~sq & hd_exec[i] & ~hd_fault[i];
      assign ns_cand = hd_nonspec[i] | hd_uncached[i];
      assign ns_v[i]     = rdy & ~sq & ~hd_exec[i] & ns_cand & first;
      assign flt_v[i]    = rdy & ~sq & hd_exec[i] & hd_fault[i] & first;
      assign commit_v[i] = ok;
      assign retire_mask[i] = sq | ok;
      assign alive[i+1] = alive[i] & (sq | ok);
      assign ncom[i+1]  = ncom[i] + CW'(ok);
   end

   assign commit_count = ncom[WIDTH];
   assign done_valid   = |commit_v;
   assign ns_req       = |ns_v;
   assign fault_hit    = |flt_v;
   assign store_commit = |(commit_v & hd_store);

   always_comb begin
      done_seq    = '0;
      ns_seq      = '0;
      ns_uncached = 1'b0;
      for (int i = 0; i < WIDTH; i++) begin
         if (commit_v[i]) done_seq = hd_seq[i*SEQ_W +: SEQ_W];
         if (ns_v[i]) begin
            ns_seq      = hd_seq[i*SEQ_W +: SEQ_W];
            ns_uncached = hd_uncached[i];
         end
      end
   end
endmodule

// File: rtl/retire_trap_timer.sv
module retire_trap_timer
   import retire_ctrl_pkg::*;
#(
   parameter int TRAP_LAT = 3,
   localparam int TW = $clog2(TRAP_LAT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic accept,
   output logic waiting,
   output logic squash
);
   rc_mode_e      mode;
   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= MODE_RUN;
         cnt  <= '0;
      end else if (mode == MODE_RUN) begin
         if (accept) begin
            mode <= MODE_WAIT;
            cnt  <= TW'(TRAP_LAT - 1);
         end
      end else if (cnt == '0) begin
         mode <= MODE_RUN;
      end else begin
         cnt <= cnt - 1'b1;
      end
   end

   assign waiting = (mode == MODE_WAIT);
   assign squash  = waiting && (cnt == '0);
endmodule

// File: rtl/retire_bw_counter.sv
module retire_bw_counter #(
   parameter int WIDTH = 4,
   parameter int CNT_W = 16,
   localparam int CW = $clog2(WIDTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CW-1:0]    commit_count,
   output logic [CNT_W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else if (commit_count == CW'(WIDTH)) count <= count + 1'b1;
   end
endmodule

// File: rtl/retire_ctrl.sv
module retire_ctrl #(
   parameter int WIDTH    = 4,
   parameter int SEQ_W    = 16,
   parameter int TRAP_LAT = 3,
   parameter int CNT_W    = 16,
   localparam int CW = $clog2(WIDTH + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [WIDTH-1:0]       head_rdy,
   input  logic [WIDTH-1:0]       hd_exec,
   input  logic [WIDTH-1:0]       hd_squashed,
   input  logic [WIDTH-1:0]       hd_nonspec,
   input  logic [WIDTH-1:0]       hd_uncached,
   input  logic [WIDTH-1:0]       hd_store,
   input  logic [WIDTH-1:0]       hd_fault,
   input  logic [WIDTH*SEQ_W-1:0] hd_seq,
   input  logic                   stores_pending,
   input  logic                   intr_pending,
   input  logic                   rob_empty,
   output logic [WIDTH-1:0]       retire_mask,
   output logic [CW-1:0]          commit_count,
   output logic                   done_valid,
   output logic [SEQ_W-1:0]       done_seq,
   output logic                   ns_req,
   output logic                   ns_uncached,
   output logic [SEQ_W-1:0]       ns_seq,
   output logic                   trap_req,
   output logic                   trap_wait,
   output logic                   trap_squash,
   output logic                   rob_empty_out,
   output logic [CNT_W-1:0]       full_bw_count
);
   if (WIDTH < 1 || WIDTH > 4) begin : g_bad_width
      $error("retire_ctrl: WIDTH must lie in 1..4");
   end
   if (TRAP_LAT < 1) begin : g_bad_lat
      $error("retire_ctrl: TRAP_LAT must be at least 1");
   end
   if (SEQ_W < 1 || CNT_W < 1) begin : g_bad_w
      $error("retire_ctrl: SEQ_W and CNT_W must be positive");
   end

   logic fault_hit, store_commit, scan_en;

   assign scan_en = ~trap_wait & ~intr_pending;

   retire_scan #(.WIDTH(WIDTH), .SEQ_W(SEQ_W)) u_scan (
      .enable         (scan_en),
      .stores_pending (stores_pending),
      .head_rdy       (head_rdy),
      .hd_exec        (hd_exec),
      .hd_squashed    (hd_squashed),
      .hd_nonspec     (hd_nonspec),
      .hd_uncached    (hd_uncached),
      .hd_store       (hd_store),
      .hd_fault       (hd_fault),
      .hd_seq         (hd_seq),
      .retire_mask    (retire_mask),
      .commit_count   (commit_count),
      .done_valid     (done_valid),
      .done_seq       (done_seq),
      .ns_req         (ns_req),
      .ns_uncached    (ns_uncached),
      .ns_seq         (ns_seq),
      .fault_hit      (fault_hit),
      .store_commit   (store_commit)
   );

   assign trap_req = fault_hit;

   retire_trap_timer #(.TRAP_LAT(TRAP_LAT)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (fault_hit),
      .waiting (trap_wait),
      .squash  (trap_squash)
   );

   retire_bw_counter #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_bw (
      .clk          (clk),
      .rst_n        (rst_n),
      .commit_count (commit_count),
      .count        (full_bw_count)
   );

   assign rob_empty_out = rob_empty & ~stores_pending & ~store_commit;
endmodule

// File: rtl/retire_ctrl_chk.sv
module retire_ctrl_chk #(
   parameter int WIDTH = 4,
   parameter int CNT_W = 16,
   localparam int CW = $clog2(WIDTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] retire_mask,
   input logic [CW-1:0]    commit_count,
   input logic             stores_pending,
   input logic             intr_pending,
   input logic             ns_req,
   input logic             trap_req,
   input logic             trap_wait,
   input logic             trap_squash,
   input logic             rob_empty_out,
   input logic [CNT_W-1:0] full_bw_count
);
   a_r1_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
      ((retire_mask & WIDTH'(retire_mask + 1'b1)) == '0));
   a_r2_count_le_retired: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(commit_count) <= $countones(retire_mask)));
   a_r3_intr_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      intr_pending |-> (retire_mask == '0 && !ns_req && !trap_req));
   a_r4_ns_first: assert property (@(posedge clk) disable iff (!rst_n)
      ns_req |-> (!stores_pending && commit_count == '0));
   a_r6_trap_first: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> (!stores_pending && commit_count == '0));
   a_r7_enter_wait: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |=> trap_wait);
   a_r7_wait_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      trap_wait |-> (retire_mask == '0 && !trap_req && !ns_req));
   a_r8_squash_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
      trap_squash |-> trap_wait);
   a_r8_squash_ends: assert property (@(posedge clk) disable iff (!rst_n)
      trap_squash |=> (!trap_wait && !trap_squash));
   a_r9_empty_no_stores: assert property (@(posedge clk) disable iff (!rst_n)
      rob_empty_out |-> !stores_pending);
   a_r10_count_up: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_count == CW'(WIDTH)) |=> (full_bw_count == $past(full_bw_count) + 1'b1));
   a_r10_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_count != CW'(WIDTH)) |=> $stable(full_bw_count));
endmodule

bind retire_ctrl retire_ctrl_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .retire_mask    (retire_mask),
   .commit_count   (commit_count),
   .stores_pending (stores_pending),
   .intr_pending   (intr_pending),
   .ns_req         (ns_req),
   .trap_req       (trap_req),
   .trap_wait      (trap_wait),
   .trap_squash    (trap_squash),
   .rob_empty_out  (rob_empty_out),
   .full_bw_count  (full_bw_count)
);

// File: tb/sim_retire_ctrl.sv
module sim_retire_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int W   = 4;
   localparam int SW  = 16;
   localparam int LAT = 3;
   localparam int CNW = 16;
   localparam int CW  = $clog2(W + 1);

   typedef struct packed {
      logic [3:0] rdy, ex, sq, ns, uc, st;
      logic       sp, ir, em;
      logic [3:0] emask;
      logic [2:0] ecnt;
      logic       ens, euc, eemp;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t TBL [NV] = '{
      '{4'b1111,4'b1111,4'b0000,4'b0000,4'b0000,4'b0000,1'b0,1'b0,1'b0, 4'b1111,3'd4,1'b0,1'b0,1'b0},
      '{4'b0011,4'b1111,4'b0000,4'b0000,4'b0000,4'b0000,1'b0,1'b0,1'b0, 4'b0011,3'd2,1'b0,1'b0,1'b0},
      '{4'b1111,4'b1111,4'b0010,4'b0000,4'b0000,4'b0000,1'b0,1'b0,1'b0, 4'b1111,3'd3,1'b0,1'b0,1'b0},
      '{4'b1111,4'b1110,4'b0000,4'b0001,4'b0000,4'b0000,1'b0,1'b0,1'b0, 4'b0000,3'd0,1'b1,1'b0,1'b0},
      '{4'b1111,4'b1110,4'b0000,4'b0001,4'b0000,4'b0000,1'b1,1'b0,1'b0, 4'b0000,3'd0,1'b0,1'b0,1'b0},
      '{4'b1111,4'b1101,4'b0000,4'b0010,4'b0000,4'b0000,1'b0,1'b0,1'b0, 4'b0001,3'd1,1'b0,1'b0,1'b0},
      '{4'b1111,4'b1110,4'b0000,4'b0000,4'b0001,4'b0000,1'b0,1'b0,1'b0, 4'b0000,3'd0,1'b1,1'b1,1'b0},
      '{4'b1111,4'b1100,4'b0001,4'b0010,4'b0000,4'b0000,1'b0,1'b0,1'b0, 4'b0001,3'd0,1'b1,1'b0,1'b0},
      '{4'b1111,4'b1111,4'b0000,4'b0000,4'b0000,4'b0000,1'b0,1'b1,1'b0, 4'b0000,3'd0,1'b0,1'b0,1'b0},
      '{4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,1'b0,1'b0,1'b1, 4'b0000,3'd0,1'b0,1'b0,1'b1},
      '{4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,1'b1,1'b0,1'b1, 4'b0000,3'd0,1'b0,1'b0,1'b0},
      '{4'b0001,4'b0001,4'b0000,4'b0000,4'b0000,4'b0001,1'b0,1'b0,1'b1, 4'b0001,3'd1,1'b0,1'b0,1'b0}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic [W-1:0] head_rdy = '0, hd_exec = '0, hd_squashed = '0, hd_nonspec = '0;
   logic [W-1:0] hd_uncached = '0, hd_store = '0, hd_fault = '0;
   logic [W*SW-1:0] hd_seq;
   logic stores_pending = 1'b0, intr_pending = 1'b0, rob_empty = 1'b0;
   logic [W-1:0] retire_mask;
   logic [CW-1:0] commit_count;
   logic done_valid, ns_req, ns_uncached, trap_req, trap_wait, trap_squash, rob_empty_out;
   logic [SW-1:0] done_seq, ns_seq;
   logic [CNW-1:0] full_bw_count;

   int n_chk = 0, n_bad = 0;

   for (genvar i = 0; i < W; i++) begin : g_seq
      assign hd_seq[i*SW +: SW] = SW'(100 + i);
   end

   always #(CLK_PERIOD/2) clk = ~clk;

   retire_ctrl #(.WIDTH(W), .SEQ_W(SW), .TRAP_LAT(LAT), .CNT_W(CNW)) u0 (.*);

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      head_rdy = '0; hd_exec = '0; hd_squashed = '0; hd_nonspec = '0;
      hd_uncached = '0; hd_store = '0; hd_fault = '0;
      stores_pending = 1'b0; intr_pending = 1'b0; rob_empty = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      #1;
      chk("R12 full_bw_count", full_bw_count, 0);
      chk("R12 trap_wait", trap_wait, 0);
      chk("R12 trap_squash", trap_squash, 0);
      rst_n = 1'b1;

      // table walk: R1 R2 R3 R4 R5 R9 R11
      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         head_rdy = TBL[v].rdy; hd_exec = TBL[v].ex; hd_squashed = TBL[v].sq;
         hd_nonspec = TBL[v].ns; hd_uncached = TBL[v].uc; hd_store = TBL[v].st;
         hd_fault = '0; stores_pending = TBL[v].sp; intr_pending = TBL[v].ir;
         rob_empty = TBL[v].em;
         #1;
         chk($sformatf("R1 mask v%0d", v), retire_mask, TBL[v].emask);
         chk($sformatf("R2 count v%0d", v), commit_count, TBL[v].ecnt);
         chk($sformatf("R4 ns_req v%0d", v), ns_req, TBL[v].ens);
         if (TBL[v].ens) begin
            chk($sformatf("R4 ns_seq v%0d", v), ns_seq, 100 + $countones(TBL[v].emask));
            chk($sformatf("R5 ns_uncached v%0d", v), ns_uncached, TBL[v].euc);
         end
         chk($sformatf("R9 empty v%0d", v), rob_empty_out, TBL[v].eemp);
         chk($sformatf("R11 done_valid v%0d", v), done_valid, (TBL[v].ecnt != 0) ? 1 : 0);
         if (TBL[v].ecnt != 0) begin
            int hi = 0;
            for (int i = 0; i < W; i++)
               if (TBL[v].emask[i] && !TBL[v].sq[i]) hi = i;
            chk($sformatf("R11 done_seq v%0d", v), done_seq, 100 + hi);
         end
         chk($sformatf("R3 trap_req v%0d", v), trap_req, 0);
      end
      @(negedge clk);
      idle_inputs();
      #1;
      chk("R10 full_bw_count after table", full_bw_count, 1);

      // R6: fault behind a commit is not accepted
      head_rdy = 4'b1111; hd_exec = 4'b1111; hd_fault = 4'b0010;
      #1;
      chk("R6 fault not first trap_req", trap_req, 0);
      chk("R6 fault not first mask", retire_mask, 4'b0001);
      // R6: fault with stores pending
      hd_fault = 4'b0001; stores_pending = 1'b1;
      #1;
      chk("R6 fault stores pending", trap_req, 0);
      chk("R6 fault stores pending mask", retire_mask, 0);
      stores_pending = 1'b0;
      #1;
      chk("R6 fault accepted", trap_req, 1);
      chk("R6 fault not retired", retire_mask, 0);
      // R7/R8 wait period
      for (int c = 1; c <= LAT; c++) begin
         @(negedge clk);
         #1;
         chk($sformatf("R7 wait c%0d", c), trap_wait, 1);
         chk($sformatf("R7 no retire c%0d", c), retire_mask, 0);
         chk($sformatf("R7 fault ignored c%0d", c), trap_req, 0);
         chk($sformatf("R8 squash c%0d", c), trap_squash, (c == LAT) ? 1 : 0);
      end
      idle_inputs();
      @(negedge clk);
      #1;
      chk("R8 wait over", trap_wait, 0);
      chk("R8 squash single", trap_squash, 0);
      head_rdy = 4'b0011; hd_exec = 4'b0011;
      #1;
      chk("R7 retire resumes", retire_mask, 4'b0011);
      @(negedge clk);
      idle_inputs();
      #1;
      chk("R10 partial bandwidth no count", full_bw_count, 1);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule